// File: doc/BRIEF.md
# Skip-Tolerant Loopback Bit-Error Detector

This block sits behind the symbol decoder of a receiver-tolerance tester. The device under test loops back a test pattern. The block compares each decoded 8-bit symbol from that stream against a locally generated copy of the pattern and counts mismatching bits. The far end's elasticity buffer inserts and deletes clock-compensation skip symbols in the stream. Each skip symbol is therefore removed before the comparison, so those edits never show up as bit errors.

Software pulses the start input. The block then seeds its pattern generator from the incoming stream and waits for a run of matching symbols before it declares lock. While locked, it accumulates two counters: the errored bits and the total compared bits. Software divides the first by the second to get the error ratio. A burst of errored symbols drops the lock and the block re-acquires on its own. The counters hold their value while the block is unlocked. A clear input zeroes both counters together.

Top module: `lb_err_detector`

## Requirements
- R1: A valid symbol with data 0x3C and the control flag set is a skip. It is discarded: it changes neither counter, raises no error pulse and does not advance the pattern generator.
- R2: The pattern is a 16-bit Fibonacci LFSR, x^16+x^5+x^4+x^3+1. Each step shifts left and feeds in s[15]^s[4]^s[3]^s[2]. Each symbol is the low byte after 8 steps. After start, the first two non-skip data symbols A then B seed the state as {A,B}.
- R3: After seeding, lock (locked_o=1) is declared on the edge of the 8th consecutive symbol that matches the pattern. A mismatch before that point returns the block to seeding.
- R4: For a compared symbol with the control flag clear, the error count grows by the popcount of (received XOR expected). With the control flag set, it grows by 8.
- R5: Each compared symbol while locked adds 8 to the total-bit count on the edge that accepts it.
- R6: While locked_o is 0, neither counter changes (except by clear).
- R7: When 16 of the last 64 compared symbols are errored, lock drops on the edge of the 16th. That symbol is still counted.
- R8: Both counters are CNT_W bits wide (default 48) and saturate at all ones instead of wrapping.
- R9: clear_i zeroes both counters on the next edge. It takes priority over a symbol counted in the same cycle.
- R10: err_pulse_o is high for exactly the one cycle after an errored symbol is compared while locked.
- R11: start_i drops lock on the next edge and restarts seeding. A symbol presented in the same cycle is ignored. The counters are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse: begin or restart pattern acquisition |
| clear_i | input | 1 | Pulse: zero both counters |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_data_i | input | 8 | Decoded symbol byte |
| sym_k_i | input | 1 | Control-symbol flag |
| err_bits_o | output | CNT_W | Saturating errored-bit count |
| tot_bits_o | output | CNT_W | Saturating compared-bit count |
| locked_o | output | 1 | Pattern lock |
| err_pulse_o | output | 1 | One-cycle errored-symbol strobe |

## Verification
Every result is registered once. The counters, locked_o and err_pulse_o all reflect a symbol one edge after the edge that accepts it. The bench drives each symbol at a falling edge, removes it at the next falling edge, and checks all outputs there, half a cycle after they settle. The bench also checks at that point that err_pulse_o has fallen again after an idle cycle.

// File: rtl/lb_err_pkg.sv
package lb_err_pkg;
  localparam logic [7:0] SKIP_BYTE = 8'h3C;

  typedef enum logic [2:0] {ST_IDLE, ST_SEED0, ST_SEED1, ST_ALIGN, ST_LOCK} lb_state_e;

  // 8 serial steps of x^16+x^5+x^4+x^3+1, newest bit at LSB
  function automatic logic [15:0] lfsr_adv8(input logic [15:0] s);
    logic [15:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[14:0], t[15] ^ t[4] ^ t[3] ^ t[2]};
    return t;
  endfunction

  function automatic logic [3:0] pop8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/lb_pattern_gen.sv
module lb_pattern_gen (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic       adv_i,
  output logic [7:0] exp_byte_o
);
  import lb_err_pkg::*;

  logic [15:0] st_q, st_nxt;

  assign st_nxt     = lfsr_adv8(st_q);
  assign exp_byte_o = st_nxt[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (load_i) st_q <= {st_q[7:0], load_byte_i};
    else if (adv_i)  st_q <= st_nxt;
  end
endmodule

// File: rtl/lb_err_window.sv
module lb_err_window #(
  parameter int WIN = 64,
  parameter int THR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic shift_i,
  input  logic err_i,
  output logic trip_o
);
  localparam int CW = $clog2(WIN + 1);

  logic [WIN-1:0] hist_q;
  logic [CW-1:0]  cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + CW'(err_i) - CW'(hist_q[WIN-1]);
  assign trip_o  = shift_i && (cnt_nxt >= CW'(THR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (shift_i) begin
      hist_q <= {hist_q[WIN-2:0], err_i};
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/lb_sat_cnt.sv
module lb_sat_cnt #(
  parameter int W     = 48,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  logic [W:0] sum;

  assign sum = {1'b0, cnt_o} + {{(W + 1 - INC_W){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (en_i)   cnt_o <= sum[W] ? '1 : sum[W-1:0];
  end
endmodule

// File: rtl/lb_err_detector.sv
module lb_err_detector #(
  parameter int CNT_W  = 48,
  parameter int LOCK_N = 8,
  parameter int WIN    = 64,
  parameter int THR    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             sym_valid_i,
  input  logic [7:0]       sym_data_i,
  input  logic             sym_k_i,
  output logic [CNT_W-1:0] err_bits_o,
  output logic [CNT_W-1:0] tot_bits_o,
  output logic             locked_o,
  output logic             err_pulse_o
);
  import lb_err_pkg::*;

  localparam int MC_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;

  lb_state_e      st_q;
  logic [MC_W-1:0] mcnt_q;
  logic [7:0]     exp_byte;
  logic [3:0]     cmp_bits;
  logic           is_skip, use_sym, match, load, adv, trip, cnt_en;

  assign is_skip  = sym_k_i && (sym_data_i == SKIP_BYTE);
  assign use_sym  = sym_valid_i && !is_skip && !start_i;
  // control flag never appears in the pattern: whole symbol counted wrong
  assign cmp_bits = sym_k_i ? 4'd8 : pop8(sym_data_i ^ exp_byte);
  assign match    = (cmp_bits == 4'd0);

  assign load   = use_sym && !sym_k_i && (st_q == ST_SEED0 || st_q == ST_SEED1);
  assign adv    = use_sym && ((st_q == ST_ALIGN && match) || st_q == ST_LOCK);
  assign cnt_en = use_sym && (st_q == ST_LOCK);

  lb_pattern_gen u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_byte_i (sym_data_i),
    .adv_i       (adv),
    .exp_byte_o  (exp_byte)
  );

  lb_err_window #(.WIN(WIN), .THR(THR)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q != ST_LOCK),
    .shift_i (cnt_en),
    .err_i   (!match),
    .trip_o  (trip)
  );

  lb_sat_cnt #(.W(CNT_W), .INC_W(4)) u_err_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .en_i   (cnt_en),
    .inc_i  (cmp_bits),
    .cnt_o  (err_bits_o)
  );

  lb_sat_cnt #(.W(CNT_W), .INC_W(4)) u_tot_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .en_i   (cnt_en),
    .inc_i  (4'd8),
    .cnt_o  (tot_bits_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mcnt_q <= '0;
    end else if (start_i) begin
      st_q   <= ST_SEED0;
      mcnt_q <= '0;
    end else if (use_sym) begin
      unique case (st_q)
        ST_SEED0: if (!sym_k_i) st_q <= ST_SEED1;
        ST_SEED1: if (!sym_k_i) begin
          st_q   <= ST_ALIGN;
          mcnt_q <= '0;
        end
        ST_ALIGN: begin
          if (!match) st_q <= ST_SEED0;
          else if (mcnt_q == MC_W'(LOCK_N - 1)) st_q <= ST_LOCK;
          else mcnt_q <= mcnt_q + 1'b1;
        end
        ST_LOCK: if (trip) st_q <= ST_SEED0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_pulse_o <= 1'b0;
    else         err_pulse_o <= cnt_en && !match;
  end

  assign locked_o = (st_q == ST_LOCK);
endmodule

// File: rtl/lb_err_detector_chk.sv
module lb_err_detector_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             clear_i,
  input logic             sym_valid_i,
  input logic [7:0]       sym_data_i,
  input logic             sym_k_i,
  input logic [CNT_W-1:0] err_bits_o,
  input logic [CNT_W-1:0] tot_bits_o,
  input logic             locked_o,
  input logic             err_pulse_o
);
  logic skip_in;
  assign skip_in = sym_valid_i && sym_k_i && (sym_data_i == 8'h3C);

  p_skip_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_in && !clear_i |=> $stable(err_bits_o) && $stable(tot_bits_o) && !err_pulse_o);

  p_err_le_tot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_bits_o <= tot_bits_o);

  p_tot_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && sym_valid_i && !skip_in && !start_i && !clear_i &&
    (tot_bits_o < {CNT_W{1'b1}} - CNT_W'(7))
    |=> tot_bits_o == $past(tot_bits_o) + CNT_W'(8));

  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o && !clear_i |=> $stable(err_bits_o) && $stable(tot_bits_o));

  p_sat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tot_bits_o == {CNT_W{1'b1}}) && !clear_i |=> tot_bits_o == {CNT_W{1'b1}});

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (err_bits_o == '0) && (tot_bits_o == '0));

  p_pulse_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> $past(locked_o));

  p_start_unlock_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !locked_o);
endmodule

bind lb_err_detector lb_err_detector_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/lb_err_detector_bench.sv
`timescale 1ns/1ps
module lb_err_detector_bench;
  localparam int CW = 12;
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, clear = 1'b0, vld = 1'b0, k = 1'b0;
  logic [7:0] data = '0;
  logic [CW-1:0] err_bits, tot_bits;
  logic locked, pulse;

  int nchk = 0, nfail = 0;
  longint e_err = 0, e_tot = 0;
  logic [15:0] st;
  int seed_dummy;

  always #4 clk = ~clk;

  lb_err_detector #(.CNT_W(CW)) u_lb_err_detector (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clear_i(clear),
    .sym_valid_i(vld), .sym_data_i(data), .sym_k_i(k),
    .err_bits_o(err_bits), .tot_bits_o(tot_bits),
    .locked_o(locked), .err_pulse_o(pulse));

  function automatic logic [15:0] nxt(input logic [15:0] s);
    logic [15:0] t = s;
    for (int i = 0; i < 8; i++) t = {t[14:0], t[15] ^ t[4] ^ t[3] ^ t[2]};
    return t;
  endfunction

  function automatic longint sat(input longint v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_cnt(input string tag);
    chk(err_bits == CW'(e_err), {tag, " err"}, err_bits, e_err);
    chk(tot_bits == CW'(e_tot), {tag, " tot"}, tot_bits, e_tot);
  endtask

  task automatic send(input logic [7:0] d, input logic kk);
    @(negedge clk); vld = 1'b1; data = d; k = kk;
    @(negedge clk); vld = 1'b0; k = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // expected pattern symbol, advancing bench state
  task automatic good(output logic [7:0] b);
    st = nxt(st); b = st[7:0];
  endtask

  task automatic acquire(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] g;
    pulse_start();
    chk(!locked, "R11 unlocked after start", locked, 0);
    send(a, 1'b0);
    send(8'h3C, 1'b1);
    send(b, 1'b0);
    st = {a, b};
    for (int i = 0; i < 8; i++) begin
      good(g); send(g, 1'b0);
      if (i == 6) chk(!locked, "R3 not locked after 7", locked, 0);
    end
    chk(locked, "R2/R3 locked after 8 matches", locked, 1);
    chk_cnt("R6 align not counted");
  endtask

  initial begin
    #(8ns * 150000);
    nfail++; nchk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] g, m;
    int gap;
    bit erred;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!locked && !pulse, "reset outputs", {locked, pulse}, 0);
    chk_cnt("reset");

    // R6: symbols before start are not counted
    send(8'h12, 1'b0);
    chk_cnt("R6 idle");

    acquire(8'h5A, 8'hC3);

    // R1: skips while locked
    send(8'h3C, 1'b1); send(8'h3C, 1'b1);
    chk_cnt("R1 skip pair locked");
    chk(!pulse, "R1 no pulse on skip", pulse, 0);

    // random phase: R4 R5 R10 R1
    gap = 10;
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 12 == 0) begin
        for (int s = 0; s <= int'($urandom % 3); s++) begin
          send(8'h3C, 1'b1);
          chk_cnt("R1 skip random");
        end
      end
      good(g);
      erred = 1'b0;
      gap++;
      if (gap >= 5 && $urandom % 6 == 0) begin
        gap = 0; erred = 1'b1;
        if ($urandom % 3 == 0 && g != 8'h3C) begin
          send(g, 1'b1); e_err = sat(e_err + 8);
        end else begin
          m = 8'($urandom % 255 + 1);
          send(g ^ m, 1'b0); e_err = sat(e_err + $countones(m));
        end
      end else send(g, 1'b0);
      e_tot = sat(e_tot + 8);
      chk(pulse == erred, "R10 pulse", pulse, erred);
      chk(locked, "R7 lock held", locked, 1);
      if (n % 25 == 0) chk_cnt("R4/R5 random");
      if (erred) begin
        @(negedge clk);
        chk(!pulse, "R10 pulse one cycle", pulse, 0);
      end
    end
    chk_cnt("R4/R5 random end");

    // R7: clean window then 16 errors
    for (int n = 0; n < 64; n++) begin good(g); send(g, 1'b0); e_tot += 8; end
    for (int n = 0; n < 16; n++) begin
      good(g); send(g ^ 8'h01, 1'b0); e_tot += 8; e_err += 1;
      if (n == 14) chk(locked, "R7 held at 15", locked, 1);
    end
    chk(!locked, "R7 dropped at 16", locked, 0);
    chk_cnt("R7 16th counted");
    for (int n = 0; n < 5; n++) begin good(g); send(g, 1'b0); end
    chk_cnt("R6 frozen unlocked");

    // R9: clear with same-cycle symbol
    acquire(8'h3B, 8'h91);
    @(negedge clk); good(g); vld = 1'b1; data = g; clear = 1'b1;
    @(negedge clk); vld = 1'b0; clear = 1'b0;
    e_err = 0; e_tot = 0;
    chk_cnt("R9 clear priority");

    // R8: saturation
    for (int n = 0; n < 512; n++) begin good(g); send(g, 1'b0); e_tot = sat(e_tot + 8); end
    chk(tot_bits == CW'(CMAX), "R8 tot saturated", tot_bits, CMAX);
    good(g); send(g ^ 8'h80, 1'b0); e_err = 1;
    chk_cnt("R8 hold at max");

    // R11: start while locked keeps counters, ignores same-cycle symbol
    @(negedge clk); good(g); vld = 1'b1; data = g ^ 8'hFF; start = 1'b1;
    @(negedge clk); vld = 1'b0; start = 1'b0;
    chk(!locked, "R11 start drops lock", locked, 0);
    chk_cnt("R11 counters kept");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule